// File: doc/BRIEF.md
# GPIO Port Register Bank with Atomic Output Updates

This block is a 32-pin general-purpose I/O port behind a simple 32-bit memory-mapped bus. The bus has a write strobe, a read strobe, a word address and write and read data. The bank keeps three registers that software can see: an output level register, a direction register and a synchronized input sample register. Each register holds one bit per pin.

Three further write-only word addresses change the output register one bit at a time. A 1 in the write data sets, clears or inverts the matching output bit. A 0 leaves that bit as it was. Software can therefore drive one pin without disturbing pins owned by other code, and it never needs a read-modify-write sequence.

The bank drives a value and an output enable for every pin. The enable follows the direction bit and the value follows the output register. Pin levels pass through a two-flop synchronizer before they can be read back.

Top module: `gpio_atomic_bank`

## Requirements
- R1: While reset is held and right after it, pin_out, pin_oe and bus_rdata are all zero. A read of the output register (word 0) or the direction register (word 5) returns zero, so every pin starts as an input.
- R2: A write to word 0 loads the full output register from bus_wdata. pin_out shows the new value after the write edge, and a later read of word 0 returns it. When no write occurs, pin_out and pin_oe do not change.
- R3: A write to word 1 sets to 1 each output bit whose bus_wdata bit is 1 and leaves every other output bit unchanged.
- R4: A write to word 2 clears to 0 each output bit whose bus_wdata bit is 1 and leaves every other output bit unchanged.
- R5: A write to word 3 inverts each output bit whose bus_wdata bit is 1 and leaves every other output bit unchanged.
- R6: A write to word 5 loads the direction register. A direction bit of 1 makes that pin an output, so pin_oe is 1. A bit of 0 makes it an input, so pin_oe is 0. A read of word 5 returns the register.
- R7: A read of word 4 returns the pin levels through a two-stage synchronizer. A level applied just before clock edge k is returned by a read strobe sampled at edge k+2 or later. Reads sampled at edges k and k+1 still return the earlier level. This holds whatever the direction bits are.
- R8: Reads of words 1, 2 and 3 return zero. Writes to word 4 and to the unused words 6 to 15 change no register. Reads of the unused words return zero.
- R9: bus_rdata is loaded at the clock edge where bus_rd is sampled high. It keeps that value until the next sampled read, including across writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pin input levels (asynchronous) |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables, 1 = driven |

## Verification
A write takes effect at the edge that samples the strobe. The bench therefore drives each strobe on a falling edge and checks pin_out and pin_oe on the next falling edge. A read result appears in bus_rdata one edge after the strobe is sampled, and the bench samples it on the falling edge that follows. For the input path, the bench changes pin_in and issues three reads on back-to-back edges. It expects the old level from the first two reads and the new level from the third, which fixes the synchronizer depth at exactly two edges.

// File: rtl/gpio_bank_pkg.sv
// Shared definitions for the GPIO register bank.
// Assumes word addressing: a byte offset divided by four gives the word index.
package gpio_bank_pkg;

    // Word index of each register; software offsets are these values times four.
    localparam int unsigned W_OUT = 0;
    localparam int unsigned W_SET = 1;
    localparam int unsigned W_CLR = 2;
    localparam int unsigned W_TOG = 3;
    localparam int unsigned W_IN  = 4;
    localparam int unsigned W_DIR = 5;

    typedef enum logic [2:0] {
        SEL_OUT  = 3'd0,
        SEL_SET  = 3'd1,
        SEL_CLR  = 3'd2,
        SEL_TOG  = 3'd3,
        SEL_IN   = 3'd4,
        SEL_DIR  = 3'd5,
        SEL_NONE = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/gpio_addr_decode.sv
// Maps a word address onto a register select.
// Assumes any address not listed is unused; unused addresses select nothing.
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    // Compare the address against each defined word index.
    always_comb begin
        if      (addr == ADDR_W'(W_OUT)) sel = SEL_OUT;
        else if (addr == ADDR_W'(W_SET)) sel = SEL_SET;
        else if (addr == ADDR_W'(W_CLR)) sel = SEL_CLR;
        else if (addr == ADDR_W'(W_TOG)) sel = SEL_TOG;
        else if (addr == ADDR_W'(W_IN))  sel = SEL_IN;
        else if (addr == ADDR_W'(W_DIR)) sel = SEL_DIR;
        else                             sel = SEL_NONE;
    end

endmodule

// File: rtl/gpio_out_regs.sv
// Holds the output level and direction registers and applies whole-word
// loads and masked set, clear and toggle updates.
// Assumes at most one write per cycle; the write is applied at the strobe edge.
module gpio_out_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  logic [NPINS-1:0] wmask,
    output logic [NPINS-1:0] out_q,
    output logic [NPINS-1:0] dir_q
);

    // Update the output register according to the selected alias.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr) begin
            case (sel)
                SEL_OUT: out_q <= wmask;
                SEL_SET: out_q <= out_q | wmask;
                SEL_CLR: out_q <= out_q & ~wmask;
                SEL_TOG: out_q <= out_q ^ wmask;
                default: out_q <= out_q;
            endcase
        end
    end

    // Load the direction register on a write to its own word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (wr && sel == SEL_DIR)
            dir_q <= wmask;
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Chain of flops that brings asynchronous pin levels into the clock domain.
// Assumes each pin is independent; no bus-wide coherence is implied.
module gpio_in_sync #(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] d,
    output logic [NPINS-1:0] q
);

    logic [NPINS-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage captures the raw pin levels.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= d;
            end
        end else begin : g_next
            // Later stages pass the previous stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_atomic_bank.sv
// GPIO port register bank: output, direction and synchronized input registers,
// plus write-only set/clear/toggle aliases of the output register.
// Assumes single-cycle strobes and NPINS no wider than the data bus.
module gpio_atomic_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe
);

    reg_sel_e          sel;
    logic [NPINS-1:0]  out_q;
    logic [NPINS-1:0]  dir_q;
    logic [NPINS-1:0]  in_q;
    logic [DATA_W-1:0] rd_next;

    gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_out_regs #(.NPINS(NPINS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .sel   (sel),
        .wmask (bus_wdata[NPINS-1:0]),
        .out_q (out_q),
        .dir_q (dir_q)
    );

    gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (in_q)
    );

    // Choose the readable register; aliases and unused words give zero.
    always_comb begin
        rd_next = '0;
        case (sel)
            SEL_OUT: rd_next[NPINS-1:0] = out_q;
            SEL_IN:  rd_next[NPINS-1:0] = in_q;
            SEL_DIR: rd_next[NPINS-1:0] = dir_q;
            default: rd_next = '0;
        endcase
    end

    // Capture read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_atomic_bank_chk.sv
// Property checker for the GPIO register bank; observes ports only.
// Assumes the default word map from the package.
module gpio_atomic_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NPINS-1:0]  pin_in,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe
);

    logic [1:0] settle_q;

    // Count edges since reset so that input checks skip the synchronizer fill.
    always_ff @(posedge clk) begin
        if (!rst_n)                settle_q <= '0;
        else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
    end

    p_rst_zero_r1: assert property (@(posedge clk)
        (!rst_n) |=> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr) |=> ($stable(pin_out) && $stable(pin_oe)));

    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(W_SET)) |=>
        (pin_out == ($past(pin_out) | $past(bus_wdata[NPINS-1:0]))));

    p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(W_CLR)) |=>
        (pin_out == ($past(pin_out) & ~$past(bus_wdata[NPINS-1:0]))));

    p_tog_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(W_TOG)) |=>
        (pin_out == ($past(pin_out) ^ $past(bus_wdata[NPINS-1:0]))));

    p_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(W_DIR)) |=>
        (pin_oe == $past(bus_wdata[NPINS-1:0])));

    p_in_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q == 2'd3 && bus_rd && bus_addr == ADDR_W'(W_IN)) |=>
        (bus_rdata[NPINS-1:0] == $past(pin_in, 3)));

    p_alias_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == ADDR_W'(W_SET) || bus_addr == ADDR_W'(W_CLR) ||
                    bus_addr == ADDR_W'(W_TOG))) |=> (bus_rdata == '0));

    p_in_wr_ign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(W_IN)) |=>
        ($stable(pin_out) && $stable(pin_oe)));

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd) |=> $stable(bus_rdata));

endmodule

bind gpio_atomic_bank gpio_atomic_bank_chk #(
    .NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/sim_gpio_atomic_bank.sv
`timescale 1ns/1ps
module sim_gpio_atomic_bank;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic        bus_rd;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] out_m;
    logic [31:0] dir_m;
    logic [31:0] rd_v;

    always #2.5 clk = ~clk;

    gpio_atomic_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic check_pins(input string req);
        check(req, pin_out, out_m);
        check(req, pin_oe, dir_m);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
        bus_wdata = '0; pin_in = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 out", pin_out, 32'h0);
        check("R1 oe", pin_oe, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(4'd0, rd_v); check("R1 out reg", rd_v, 32'h0);
        rd(4'd5, rd_v); check("R1 dir reg", rd_v, 32'h0);
        out_m = '0; dir_m = '0;

        // R2: whole-word loads and readback
        foreach (rd_v[i]) begin
            out_m = 32'h1 << i;
            wr(4'd0, out_m); check_pins("R2 walk");
            rd(4'd0, rd_v); check("R2 readback", rd_v, out_m);
        end
        out_m = 32'hA5C3_0F96; wr(4'd0, out_m); check_pins("R2 pattern");
        repeat (3) @(negedge clk); check_pins("R2 idle hold");

        // R9: read data holds until the next read, across writes
        rd(4'd0, rd_v); check("R9 capture", rd_v, out_m);
        wr(4'd5, 32'h0000_FFFF); dir_m = 32'h0000_FFFF;
        check("R9 hold over write", bus_rdata, 32'hA5C3_0F96);
        @(negedge clk); check("R9 hold idle", bus_rdata, 32'hA5C3_0F96);

        // R6: direction register drives enables
        for (int k = 0; k < 4; k++) begin
            dir_m = {8{4'(4'h3 << k)}} ^ 32'hF0F0_0000;
            wr(4'd5, dir_m); check_pins("R6 dir");
            rd(4'd5, rd_v); check("R6 readback", rd_v, dir_m);
        end

        // R3: set each bit from a mixed start, plus a multi-bit mask
        out_m = 32'h0F0F_0F0F; wr(4'd0, out_m);
        for (int i = 0; i < 32; i += 3) begin
            out_m = out_m | (32'h1 << i);
            wr(4'd1, 32'h1 << i); check_pins("R3 set bit");
        end
        out_m = out_m | 32'h8001_2400; wr(4'd1, 32'h8001_2400); check_pins("R3 set mask");
        rd(4'd0, rd_v); check("R3 readback", rd_v, out_m);

        // R4: clear each bit
        out_m = 32'hFFFF_FFFF; wr(4'd0, out_m);
        for (int i = 0; i < 32; i += 2) begin
            out_m = out_m & ~(32'h1 << i);
            wr(4'd2, 32'h1 << i); check_pins("R4 clr bit");
        end
        out_m = out_m & ~32'h0F00_00F0; wr(4'd2, 32'h0F00_00F0); check_pins("R4 clr mask");
        rd(4'd0, rd_v); check("R4 readback", rd_v, out_m);

        // R5: toggle each bit twice
        for (int i = 0; i < 32; i++) begin
            out_m = out_m ^ (32'h1 << i);
            wr(4'd3, 32'h1 << i); check_pins("R5 tog bit");
        end
        for (int i = 0; i < 32; i++) begin
            out_m = out_m ^ (32'h1 << i);
            wr(4'd3, 32'h1 << i);
        end
        check_pins("R5 tog back");
        out_m = out_m ^ 32'h5A5A_5A5A; wr(4'd3, 32'h5A5A_5A5A); check_pins("R5 tog mask");

        // R8: alias reads zero, ignored writes
        rd(4'd1, rd_v); check("R8 set reads zero", rd_v, 32'h0);
        rd(4'd2, rd_v); check("R8 clr reads zero", rd_v, 32'h0);
        rd(4'd3, rd_v); check("R8 tog reads zero", rd_v, 32'h0);
        wr(4'd4, 32'hFFFF_FFFF); check_pins("R8 in write ignored");
        for (int a = 6; a < 16; a++) begin
            wr(4'(a), ~out_m); check_pins("R8 unused write ignored");
            rd(4'(a), rd_v); check("R8 unused reads zero", rd_v, 32'h0);
        end
        rd(4'd0, rd_v); check("R8 out kept", rd_v, out_m);
        rd(4'd5, rd_v); check("R8 dir kept", rd_v, dir_m);

        // R7: two-edge input synchronizer latency, any direction setting
        for (int p = 0; p < 4; p++) begin
            logic [31:0] old_v;
            logic [31:0] new_v;
            old_v = pin_in;
            new_v = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h1234_8765 :
                    (p == 2) ? 32'h0 : 32'hC0DE_F00D;
            if (p == 2) begin dir_m = 32'hFFFF_FFFF; wr(4'd5, dir_m); end
            pin_in = new_v;
            rd(4'd4, rd_v); check("R7 first edge old", rd_v, old_v);
            rd(4'd4, rd_v); check("R7 second edge old", rd_v, old_v);
            rd(4'd4, rd_v); check("R7 third edge new", rd_v, new_v);
            check_pins("R7 pins unaffected");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule